// File: doc/BRIEF.md
# Packed-Lane Logical Shifter

The block shifts a 64-bit word that holds packed lanes of equal width. Every lane of operand A moves left or right by the same count, which is taken from operand B. Vacated positions are filled with zeros. Bits pushed past the edge of a lane are dropped; they never reach a neighbouring lane. The lane width is 8, 16, 32 or 64 bits, chosen by a two-bit size code. The block is purely combinational.

The shift runs as two stages. The bit stage moves every byte by the low three count bits, 0 to 7 positions. For each byte it produces a part that stays in the byte and a part that spills into the next byte. The byte stage then builds each result byte by OR-ing two byte-selecting multiplexers. One takes a staying part and the other takes a spilled part. The selectors for these multiplexers depend only on the count, the size and the direction, so they are decoded while the bit stage works. Left and right shifts use separate paths, and a final multiplexer picks the requested one.

Top module: `lane_shifter`

## Requirements
- R1: With `dir_right` = 0, each lane is shifted left by the effective count. Zeros enter at the lane's low end, and bits leaving its high end are discarded.
- R2: With `dir_right` = 1, each lane is shifted right logically by the effective count. Zeros enter at the lane's high end, and bits leaving its low end are discarded.
- R3: The effective count is `op_b` modulo the lane width, which means the low 3, 4, 5 or 6 bits of `op_b`. All higher bits of `op_b` have no effect on `res`.
- R4: `lane_sz` encodes the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Lanes start at bit 0 and are packed contiguously.
- R5: `dir_right` selects the direction: 0 = left, 1 = right.
- R6: An effective count of zero returns `op_a` unchanged for every size and direction.
- R7: An effective count of lane width minus one keeps only one bit per lane. A left shift moves the lane's LSB to its MSB. A right shift moves the lane's MSB to its LSB.
- R8: Every bit of `res` is either a copy of one bit of `op_a` or zero. An all-zero `op_a` therefore gives an all-zero `res`.
- R9: The same effective count applies to every lane. No data crosses from one lane into another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | Packed lanes to be shifted |
| op_b | input | 64 | Shift count source; only the low bits selected by the lane size are used |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| lane_sz | input | 2 | Lane width code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| res | output | 64 | Shifted lanes |

## Verification
The block has no storage, so any wrong internal value shows at `res` in the same cycle as the inputs that expose it. A wrong bit-stage select corrupts bit positions inside every byte. A wrong byte selector moves whole bytes into the wrong place, or lets them leak across a lane edge. This shows most clearly at counts of zero and of lane width minus one, and with single-bit patterns at lane edges. Random operands compared against a per-lane model cover every size and both directions, and any mismatch appears on the very vector that triggered it.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_B64 = 2'd3
  } lane_sz_e;

  // Lane width in bytes for a size code.
  function automatic int unsigned lane_bytes(input lane_sz_e sz);
    return 32'd1 << sz;
  endfunction
endpackage

// File: rtl/lsh_bit_stage.sv
// Sub-byte shift: every byte moves by 0..7 bits.
// "main" is the part that stays in the byte, "spill" is the part that
// crosses into the neighbour (upward for left, downward for right).
module lsh_bit_stage
  import lsh_pkg::*;
#(
  parameter int unsigned NBYTES = 8
) (
  input  logic [NBYTES*BYTE_W-1:0] din,
  input  logic [2:0]               bsh,
  output logic [NBYTES*BYTE_W-1:0] l_main,
  output logic [NBYTES*BYTE_W-1:0] l_spill,
  output logic [NBYTES*BYTE_W-1:0] r_main,
  output logic [NBYTES*BYTE_W-1:0] r_spill
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [2*BYTE_W-1:0] wide_l;
    logic [2*BYTE_W-1:0] wide_r;
    assign wide_l = {{BYTE_W{1'b0}}, din[g*BYTE_W +: BYTE_W]} << bsh;
    assign wide_r = {din[g*BYTE_W +: BYTE_W], {BYTE_W{1'b0}}} >> bsh;
    assign l_main [g*BYTE_W +: BYTE_W] = wide_l[BYTE_W-1:0];
    assign l_spill[g*BYTE_W +: BYTE_W] = wide_l[2*BYTE_W-1:BYTE_W];
    assign r_main [g*BYTE_W +: BYTE_W] = wide_r[2*BYTE_W-1:BYTE_W];
    assign r_spill[g*BYTE_W +: BYTE_W] = wide_r[BYTE_W-1:0];
  end
endmodule

// File: rtl/lsh_sel_decode.sv
// Byte-selector decode: depends only on count, lane size and direction,
// so it settles in parallel with the bit stage. A selector value of
// NBYTES or above means "zero byte".
module lsh_sel_decode
  import lsh_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned SEL_W  = 4
) (
  input  logic [CNT_W-1:0]        cnt,
  input  logic [1:0]              lane_sz,
  output logic [NBYTES*SEL_W-1:0] l_main_sel,
  output logic [NBYTES*SEL_W-1:0] l_spill_sel,
  output logic [NBYTES*SEL_W-1:0] r_main_sel,
  output logic [NBYTES*SEL_W-1:0] r_spill_sel
);
  localparam logic [SEL_W-1:0] ZSEL = SEL_W'(NBYTES);

  always_comb begin
    int lb;
    int ceff;
    int kb;
    int base;
    int src;
    lb   = int'(lane_bytes(lane_sz_e'(lane_sz)));
    ceff = int'(cnt) & (lb * int'(BYTE_W) - 1);
    kb   = ceff / int'(BYTE_W);
    for (int j = 0; j < int'(NBYTES); j++) begin
      base = j - (j % lb);
      // left: staying part from byte j-kb, spilled part from j-kb-1
      src = j - kb;
      l_main_sel[j*SEL_W +: SEL_W]  = (src >= base) ? SEL_W'(src) : ZSEL;
      src = j - kb - 1;
      l_spill_sel[j*SEL_W +: SEL_W] = (src >= base) ? SEL_W'(src) : ZSEL;
      // right: staying part from byte j+kb, spilled part from j+kb+1
      src = j + kb;
      r_main_sel[j*SEL_W +: SEL_W]  = (src < base + lb) ? SEL_W'(src) : ZSEL;
      src = j + kb + 1;
      r_spill_sel[j*SEL_W +: SEL_W] = (src < base + lb) ? SEL_W'(src) : ZSEL;
    end
  end
endmodule

// File: rtl/lsh_byte_stage.sv
// Byte assembly: each result byte is the OR of two byte-wide muxes.
module lsh_byte_stage
  import lsh_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned SEL_W  = 4
) (
  input  logic [NBYTES*BYTE_W-1:0] main_in,
  input  logic [NBYTES*BYTE_W-1:0] spill_in,
  input  logic [NBYTES*SEL_W-1:0]  main_sel,
  input  logic [NBYTES*SEL_W-1:0]  spill_sel,
  output logic [NBYTES*BYTE_W-1:0] dout
);
  for (genvar j = 0; j < NBYTES; j++) begin : g_out
    logic [BYTE_W-1:0] m_byte;
    logic [BYTE_W-1:0] s_byte;
    always_comb begin
      m_byte = '0;
      s_byte = '0;
      for (int i = 0; i < int'(NBYTES); i++) begin
        if (main_sel[j*SEL_W +: SEL_W] == SEL_W'(i))
          m_byte = main_in[i*BYTE_W +: BYTE_W];
        if (spill_sel[j*SEL_W +: SEL_W] == SEL_W'(i))
          s_byte = spill_in[i*BYTE_W +: BYTE_W];
      end
    end
    assign dout[j*BYTE_W +: BYTE_W] = m_byte | s_byte;
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import lsh_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              dir_right,
  input  logic [1:0]        lane_sz,
  output logic [DATA_W-1:0] res
);
  localparam int unsigned NBYTES = DATA_W / BYTE_W;
  localparam int unsigned CNT_W  = $clog2(DATA_W);
  localparam int unsigned SEL_W  = $clog2(NBYTES) + 1;

  logic [CNT_W-1:0]        cnt;
  logic [DATA_W-1:CNT_W]   unused_b_hi;
  logic [DATA_W-1:0]       l_main, l_spill, r_main, r_spill;
  logic [NBYTES*SEL_W-1:0] l_msel, l_ssel, r_msel, r_ssel;
  logic [DATA_W-1:0]       y_left, y_right;

  assign cnt         = op_b[CNT_W-1:0];
  assign unused_b_hi = op_b[DATA_W-1:CNT_W];

  lsh_bit_stage #(.NBYTES(NBYTES)) u_bits (
    .din     (op_a),
    .bsh     (op_b[2:0]),
    .l_main  (l_main),
    .l_spill (l_spill),
    .r_main  (r_main),
    .r_spill (r_spill)
  );

  lsh_sel_decode #(.NBYTES(NBYTES), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_dec (
    .cnt         (cnt),
    .lane_sz     (lane_sz),
    .l_main_sel  (l_msel),
    .l_spill_sel (l_ssel),
    .r_main_sel  (r_msel),
    .r_spill_sel (r_ssel)
  );

  lsh_byte_stage #(.NBYTES(NBYTES), .SEL_W(SEL_W)) u_left (
    .main_in   (l_main),
    .spill_in  (l_spill),
    .main_sel  (l_msel),
    .spill_sel (l_ssel),
    .dout      (y_left)
  );

  lsh_byte_stage #(.NBYTES(NBYTES), .SEL_W(SEL_W)) u_right (
    .main_in   (r_main),
    .spill_in  (r_spill),
    .main_sel  (r_msel),
    .spill_sel (r_ssel),
    .dout      (y_right)
  );

  assign res = dir_right ? y_right : y_left;
endmodule

// File: rtl/lsh_checker.sv
module lsh_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              dir_right,
  input logic [1:0]        lane_sz,
  input logic [DATA_W-1:0] res
);
  always_comb begin
    int lw;
    int c;
    lw = 8 << lane_sz;
    c  = int'(op_b[5:0]) % lw;
    if (!$isunknown({op_a, op_b, dir_right, lane_sz, res})) begin
      // R6: zero effective count passes A through
      if (c == 0) a_r6_zero_count: assert (res == op_a)
        else $error("R6 zero count altered data");
      // R8: no bit is created from nothing
      a_r8_no_new_bits: assert ($countones(res) <= $countones(op_a))
        else $error("R8 more ones than operand");
      // R1: left shift puts a zero into bit 0
      if (!dir_right && c != 0) a_r1_left_fill: assert (res[0] == 1'b0)
        else $error("R1 lsb not zero-filled");
      // R2: right shift puts a zero into the top bit
      if (dir_right && c != 0) a_r2_right_fill: assert (res[DATA_W-1] == 1'b0)
        else $error("R2 msb not zero-filled");
      // R7: maximal count keeps at most one bit per lane
      if (c == lw - 1) a_r7_one_bit_per_lane: assert ($countones(res) <= DATA_W / lw)
        else $error("R7 too many bits survive");
    end
  end
endmodule

bind lane_shifter lsh_checker #(.DATA_W(DATA_W)) u_lsh_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .dir_right (dir_right),
  .lane_sz   (lane_sz),
  .res       (res)
);

// File: tb/test_lane_shifter.sv
`timescale 1ns/1ps
module test_lane_shifter;
  logic        clk = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        dir_right = 1'b0;
  logic [1:0]  lane_sz = 2'd0;
  logic [63:0] res;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  lane_shifter i_lane_shifter (
    .op_a(op_a), .op_b(op_b), .dir_right(dir_right), .lane_sz(lane_sz), .res(res)
  );

  // Per-lane reference: count is B modulo lane width (R3, R4).
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic d, input logic [1:0] sz);
    logic [63:0] y;
    int lw;
    int c;
    int src;
    y  = '0;
    lw = 8 << sz;
    c  = int'(b[5:0]) % lw;
    for (int base = 0; base < 64; base += lw)
      for (int i = 0; i < lw; i++) begin
        src = d ? i + c : i - c;
        if (src >= 0 && src < lw) y[base+i] = a[base+src];
      end
    return y;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input logic d, input logic [1:0] sz);
    @(posedge clk);
    op_a = a; op_b = b; dir_right = d; lane_sz = sz;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h dir=%0d sz=%0d got %h expected %h",
               req, op_a, op_b, dir_right, lane_sz, res, exp);
    end
  endtask

  // R8: all-zero operand gives all-zero result
  task automatic t_zero_operand();
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 2; d++) begin
        drive('0, {$urandom, $urandom}, d[0], s[1:0]);
        check("R8", 64'h0);
      end
  endtask

  // R6 with R3: count bits above the lane width set, effective count zero
  task automatic t_zero_count();
    logic [63:0] a;
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 2; d++) begin
        a = {$urandom, $urandom};
        drive(a, {$urandom, $urandom} << 6, d[0], s[1:0]);
        check("R6", a);
      end
  endtask

  // R7: count of lane width minus one
  task automatic t_max_count();
    for (int s = 0; s < 4; s++) begin
      int lw;
      lw = 8 << s;
      drive(64'hFFFF_FFFF_FFFF_FFFF, 64'(lw - 1), 1'b0, s[1:0]);
      // left: only each lane's MSB survives
      check("R7", model(64'hFFFF_FFFF_FFFF_FFFF, 64'(lw - 1), 1'b0, s[1:0]));
      drive(64'hFFFF_FFFF_FFFF_FFFF, 64'(lw - 1), 1'b1, s[1:0]);
      check("R7", model(64'hFFFF_FFFF_FFFF_FFFF, 64'(lw - 1), 1'b1, s[1:0]));
    end
    drive(64'h0000_0001_0000_0001, 64'd31, 1'b0, 2'd2);
    check("R7", 64'h8000_0000_8000_0000);
    drive(64'h8000_0000_0000_0000, 64'd63, 1'b1, 2'd3);
    check("R7", 64'h0000_0000_0000_0001);
  endtask

  // R1, R2, R9: lane edges drop bits, same count in all lanes
  task automatic t_lane_edges();
    drive(64'h8080_8080_8080_8080, 64'd1, 1'b0, 2'd0);
    check("R1", 64'h0);
    drive(64'h8080_8080_8080_8080, 64'd1, 1'b1, 2'd0);
    check("R2", 64'h4040_4040_4040_4040);
    drive(64'h0001_0001_0001_0001, 64'd1, 1'b1, 2'd1);
    check("R9", 64'h0);
    drive(64'h00FF_00FF_00FF_00FF, 64'd12, 1'b0, 2'd1);
    check("R9", 64'hF000_F000_F000_F000);
    drive(64'h1234_5678_9ABC_DEF0, 64'd8, 1'b0, 2'd3);
    check("R1", 64'h3456_789A_BCDE_F000);
    drive(64'h1234_5678_9ABC_DEF0, 64'd20, 1'b1, 2'd3);
    check("R2", 64'h0000_0123_4567_89AB);
  endtask

  // R3: bits above the lane's count field are ignored
  task automatic t_high_bits_ignored();
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 8; n++) begin
        logic [63:0] a, b;
        a = {$urandom, $urandom};
        b = {$urandom, $urandom};
        drive(a, b, n[0], s[1:0]);
        check("R3", model(a, b & 64'((8 << s) - 1), n[0], s[1:0]));
      end
  endtask

  // R4, R5: random operands for each size and direction
  task automatic t_random();
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 2; d++)
        for (int n = 0; n < 100; n++) begin
          logic [63:0] a, b;
          a = {$urandom, $urandom};
          b = 64'($urandom);
          drive(a, b, d[0], s[1:0]);
          check(d ? "R5/R4 right" : "R5/R4 left", model(a, b, d[0], s[1:0]));
        end
  endtask

  initial begin
    #(8.0 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R8 idle", 64'h0);
    t_zero_operand();
    t_zero_count();
    t_max_count();
    t_lane_edges();
    t_high_bits_ignored();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule